// File: doc/BRIEF.md
# Byte-Addressed I2C Target with Auto-Incrementing Pointer

This block is the serial front end of a 32K x 8 memory-mapped device. It samples SCL and SDA with a fast system clock. Each line passes through a synchronizer and a small majority filter. The block then finds START, repeated START and STOP conditions and the SCL edges. It answers to one fixed 7-bit device address. A write-mode transfer carries two pointer bytes, high byte first. Any bytes that follow are stored at the pointer, which steps forward on each acknowledge clock. A read-mode transfer sends bytes from the pointer, most significant bit first, and keeps going while the master acknowledges.

Storage sits outside the block and is reached through a plain synchronous port: an address, write data, a one-cycle write strobe, and read data that must be valid a few cycles after the address settles. The port has no back-pressure, so the storage must accept every strobe in the cycle it is issued. The register block next to this one gets two signals: a flag marking the interval in which the address on the port is being read out, and a one-cycle pulse on every STOP. A supply-fail input aborts any transfer, clears the pointer and makes the block ignore the bus for as long as the input is high.

Top module: `i2c_ptr_slave`

## Requirements
- R1: A device-address byte whose upper seven bits are 1101000 is acknowledged (SDA driven low during the ninth clock). Any other address is not acknowledged, and every later byte is also left unacknowledged and unstored until the next START.
- R2: After a write-mode device address (byte D0h), the next two bytes load the pointer, high byte first. Bit 7 of the high byte is discarded, so the pointer is {high[6:0], low[7:0]}.
- R3: In write mode each pointer byte and each data byte is acknowledged. Each data byte produces exactly one one-cycle write strobe, carrying that byte and the current pointer.
- R4: The pointer advances by one only on an acknowledge clock that follows a data byte (read or written). Stepping past 7FFFh wraps it to 0000h.
- R5: A transfer that opens with the read-mode device address (D1h) and has no pointer bytes returns the byte at the pointer as it was last left. After a read burst that ends in a NACK, this is the address of the last byte sent.
- R6: Read data leaves MSB first and changes only after SCL falls. A master ACK moves on to the next address. A master NACK makes the block release SDA and stay silent until a START.
- R7: START and repeated START (SDA falling while SCL is high) restart address decoding from any state. A STOP (SDA rising while SCL is high) returns the block to idle and raises the STOP pulse for exactly one cycle.
- R8: While the supply-fail input is high, SDA is released, no write strobe is issued, bus activity is ignored and the pointer is held at 0000h.
- R9: The read-active flag is high for the whole read-mode data phase and low in every write or idle phase.
- R10: After reset, SDA is released, the pointer is 0000h, and the write strobe, read-active flag and STOP pulse are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain), 0 releases it |
| pfail_i | input | 1 | Supply-fail indication, active high |
| mem_addr_o | output | 15 | Storage address, equal to the pointer |
| mem_wdata_o | output | 8 | Byte to store |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_rdata_i | input | 8 | Byte stored at mem_addr_o |
| rd_active_o | output | 1 | High while the byte at mem_addr_o is being read out |
| stop_seen_o | output | 1 | One-cycle pulse on each STOP |

## Verification
The assertions rely on these conditions:
- The master changes SDA only while SCL is low, except for START and STOP conditions.
- Each SCL high or low phase lasts well beyond the seven or so clocks of synchronizer and filter delay.
- The storage returns read data within a few cycles.

The bench master holds every quarter bit for ten system clocks and moves SDA only at quarter points where SCL is low. The bench storage answers one cycle after the address. Supply-fail is raised and dropped only between clock edges, for many cycles at a time.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } xfer_st_t;

  typedef enum logic [1:0] {
    RP_DATA,
    RP_REL,
    RP_MACK,
    RP_LOAD
  } rd_ph_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int HALF = FILT_TAPS / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_TAPS-1:0]   hist_q;

  // idle bus level is high, so everything resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      hist_q  <= '1;
      clean_o <= 1'b1;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], raw_i};
      hist_q  <= {hist_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      clean_o <= ($countones(hist_q) > HALF);
    end
  end
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_c,
  input  logic sda_c,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_c;
      sda_q <= sda_c;
    end
  end

  assign scl_rise = scl_c & ~scl_q;
  assign scl_fall = ~scl_c & scl_q;
  // SDA moving while SCL stays high marks a bus condition
  assign start_ev = scl_c & scl_q & sda_q & ~sda_c;
  assign stop_ev  = scl_c & scl_q & ~sda_q & sda_c;
endmodule

// File: rtl/i2cs_xfer_fsm.sv
module i2cs_xfer_fsm
  import i2cs_pkg::*;
#(
  parameter int         ADDR_W   = 15,
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfail_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_c,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              rd_active,
  output logic              stop_seen
);
  localparam int HI_W = ADDR_W - BYTE_W;

  xfer_st_t          st;
  rd_ph_t            rph;
  logic [2:0]        cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [HI_W-1:0]   ptr_hi;
  logic [ADDR_W-1:0] ptr;
  logic              ack_pend;
  logic              in_ack;
  logic              rw_bit;
  logic [BYTE_W-1:0] rx_next;

  assign rx_next   = {rx_sh[BYTE_W-2:0], sda_c};
  assign mem_addr  = ptr;
  assign rd_active = (st == ST_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      rph       <= RP_DATA;
      cnt       <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ptr_hi    <= '0;
      ptr       <= '0;
      ack_pend  <= 1'b0;
      in_ack    <= 1'b0;
      rw_bit    <= 1'b0;
      sda_oe    <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      stop_seen <= 1'b0;
    end else begin
      mem_we    <= 1'b0;
      stop_seen <= 1'b0;
      if (pfail_i) begin
        st       <= ST_IDLE;
        rph      <= RP_DATA;
        ptr      <= '0;
        cnt      <= '0;
        sda_oe   <= 1'b0;
        ack_pend <= 1'b0;
        in_ack   <= 1'b0;
      end else if (start_ev) begin
        st       <= ST_DEV;
        rph      <= RP_DATA;
        cnt      <= '0;
        sda_oe   <= 1'b0;
        ack_pend <= 1'b0;
        in_ack   <= 1'b0;
      end else if (stop_ev) begin
        st        <= ST_IDLE;
        rph       <= RP_DATA;
        sda_oe    <= 1'b0;
        ack_pend  <= 1'b0;
        in_ack    <= 1'b0;
        stop_seen <= 1'b1;
      end else begin
        case (st)
          ST_IDLE: ;
          ST_RD: begin
            if (scl_rise) begin
              case (rph)
                RP_DATA: begin
                  if (cnt == 3'd7) begin
                    cnt <= '0;
                    rph <= RP_REL;
                  end else begin
                    cnt <= cnt + 3'd1;
                  end
                end
                RP_MACK: begin
                  if (!sda_c) begin
                    ptr <= ptr + 1'b1;
                    rph <= RP_LOAD;
                  end else begin
                    st  <= ST_IDLE;
                    rph <= RP_DATA;
                  end
                end
                default: ;
              endcase
            end else if (scl_fall) begin
              case (rph)
                RP_DATA: begin
                  sda_oe <= ~tx_sh[BYTE_W-1];
                  tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
                RP_REL: begin
                  sda_oe <= 1'b0;
                  rph    <= RP_MACK;
                end
                RP_LOAD: begin
                  sda_oe <= ~mem_rdata[BYTE_W-1];
                  tx_sh  <= {mem_rdata[BYTE_W-2:0], 1'b0};
                  rph    <= RP_DATA;
                end
                default: ;
              endcase
            end
          end
          default: begin
            if (scl_rise && !in_ack) begin
              rx_sh <= rx_next;
              cnt   <= cnt + 3'd1;
              if (cnt == 3'd7) begin
                case (st)
                  ST_DEV: begin
                    if (rx_next[7:1] == DEV_ADDR) begin
                      ack_pend <= 1'b1;
                      rw_bit   <= rx_next[0];
                    end else begin
                      st <= ST_IDLE;
                    end
                  end
                  ST_AHI: begin
                    ptr_hi   <= rx_next[HI_W-1:0];
                    ack_pend <= 1'b1;
                  end
                  ST_ALO: begin
                    ptr      <= {ptr_hi, rx_next};
                    ack_pend <= 1'b1;
                  end
                  ST_WR: begin
                    mem_we    <= 1'b1;
                    mem_wdata <= rx_next;
                    ack_pend  <= 1'b1;
                  end
                  default: ;
                endcase
              end
            end else if (scl_rise && in_ack) begin
              if (st == ST_WR) ptr <= ptr + 1'b1;
            end else if (scl_fall && ack_pend) begin
              sda_oe   <= 1'b1;
              ack_pend <= 1'b0;
              in_ack   <= 1'b1;
            end else if (scl_fall && in_ack) begin
              in_ack <= 1'b0;
              cnt    <= '0;
              case (st)
                ST_DEV: begin
                  if (rw_bit) begin
                    st     <= ST_RD;
                    rph    <= RP_DATA;
                    sda_oe <= ~mem_rdata[BYTE_W-1];
                    tx_sh  <= {mem_rdata[BYTE_W-2:0], 1'b0};
                  end else begin
                    st     <= ST_AHI;
                    sda_oe <= 1'b0;
                  end
                end
                ST_AHI: begin
                  st     <= ST_ALO;
                  sda_oe <= 1'b0;
                end
                default: begin
                  st     <= ST_WR;
                  sda_oe <= 1'b0;
                end
              endcase
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave #(
  parameter int         ADDR_W      = 15,
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_TAPS   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              pfail_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              rd_active_o,
  output logic              stop_seen_o
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] clean_lines;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2cs_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_TAPS  (FILT_TAPS)
    ) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_lines[g]),
      .clean_o(clean_lines[g])
    );
  end

  i2cs_bus_events u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_c   (clean_lines[0]),
    .sda_c   (clean_lines[1]),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  i2cs_xfer_fsm #(
    .ADDR_W  (ADDR_W),
    .DEV_ADDR(DEV_ADDR)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pfail_i  (pfail_i),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_c    (clean_lines[1]),
    .mem_rdata(mem_rdata_i),
    .sda_oe   (sda_oe_o),
    .mem_addr (mem_addr_o),
    .mem_wdata(mem_wdata_o),
    .mem_we   (mem_we_o),
    .rd_active(rd_active_o),
    .stop_seen(stop_seen_o)
  );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pfail_i,
  input logic              sda_oe_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              rd_active_o,
  input logic              stop_seen_o
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o); // R3

  AST_PTR_STEP_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active_o && $past(rd_active_o) && !$past(pfail_i) && (mem_addr_o != $past(mem_addr_o)))
      |-> (mem_addr_o == $past(mem_addr_o) + ONE)); // R4

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen_o |-> (!sda_oe_o && !rd_active_o)); // R7

  AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen_o |=> !stop_seen_o); // R7

  AST_PFAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (pfail_i && $past(pfail_i)) |-> !mem_we_o); // R8

  AST_PFAIL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pfail_i) |-> ((mem_addr_o == '0) && !sda_oe_o && !rd_active_o)); // R8

  AST_NO_WRITE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !rd_active_o); // R9
endmodule

bind i2c_ptr_slave i2cs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pfail_i    (pfail_i),
  .sda_oe_o   (sda_oe_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .rd_active_o(rd_active_o),
  .stop_seen_o(stop_seen_o)
);

// File: tb/tb_i2c_ptr_slave.sv
module tb_i2c_ptr_slave;
  localparam int Q    = 10;
  localparam int NVEC = 4;
  // entry: {high pointer byte, low pointer byte, first data byte, burst length}
  localparam logic [27:0] VEC [NVEC] = '{
    {8'h00, 8'h10, 8'hA5, 4'd3},
    {8'h7F, 8'hFE, 8'h3C, 4'd4},
    {8'h81, 8'h20, 8'h5A, 4'd2},
    {8'h12, 8'h34, 8'hC0, 4'd5}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        pfail = 1'b0;
  logic        sda_oe, mem_we, rd_active, stop_seen;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_ptr_slave dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .sda_oe_o   (sda_oe),
    .pfail_i    (pfail),
    .mem_addr_o (mem_addr),
    .mem_wdata_o(mem_wdata),
    .mem_we_o   (mem_we),
    .mem_rdata_i(mem_rdata),
    .rd_active_o(rd_active),
    .stop_seen_o(stop_seen)
  );

  // small storage model: 64 bytes indexed by the low pointer bits
  logic [7:0]  bmem [64];
  logic [14:0] wlog_a [32];
  logic [7:0]  wlog_d [32];
  int          wcnt;
  int          stop_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) bmem[i] <= 8'hEE;
      wcnt      <= 0;
      stop_cnt  <= 0;
      mem_rdata <= 8'h00;
    end else begin
      if (mem_we) begin
        bmem[mem_addr[5:0]] <= mem_wdata;
        if (wcnt < 32) begin
          wlog_a[wcnt] <= mem_addr;
          wlog_d[wcnt] <= mem_wdata;
        end
        wcnt <= wcnt + 1;
      end
      if (stop_seen) stop_cnt <= stop_cnt + 1;
      mem_rdata <= bmem[mem_addr[5:0]];
    end
  end

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 1'b0;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b1; waitq();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; waitq();
    scl_m = 1'b1; waitq();
    s = sda_bus; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic nak);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    clk_bit(1'b1, nak);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v, output logic rd_seen);
    logic s;
    rd_seen = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; waitq();
      scl_m = 1'b1; waitq();
      v[i] = sda_bus;
      rd_seen = rd_seen & rd_active;
      waitq();
      scl_m = 1'b0; waitq();
    end
    clk_bit(mack, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic        nak, rd_seen, all_ack, rd_all;
    logic [7:0]  v;
    logic [14:0] eptr;
    int          wbase, sbase;

    repeat (5) @(negedge clk);
    // R10: reset values
    check(sda_oe == 1'b0, "R10 sda released", sda_oe, 0);
    check(mem_addr == 15'h0, "R10 pointer", mem_addr, 0);
    check(mem_we == 1'b0 && rd_active == 1'b0 && stop_seen == 1'b0, "R10 strobes",
          {mem_we, rd_active, stop_seen}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int n = 0; n < NVEC; n++) begin
      logic [7:0] hi, lo, d0;
      int         len;
      hi   = VEC[n][27:20];
      lo   = VEC[n][19:12];
      d0   = VEC[n][11:4];
      len  = int'(VEC[n][3:0]);
      eptr = {hi[6:0], lo};

      // write burst
      wbase   = wcnt;
      all_ack = 1'b1;
      bus_start();
      send_byte(8'hD0, nak); all_ack &= ~nak;
      send_byte(hi, nak);    all_ack &= ~nak;
      send_byte(lo, nak);    all_ack &= ~nak;
      for (int i = 0; i < len; i++) begin
        send_byte(d0 + 8'(i), nak);
        all_ack &= ~nak;
      end
      bus_stop();
      check(all_ack, "R3 write burst acknowledged", all_ack, 1);
      check(wcnt - wbase == len, "R3 one strobe per byte", wcnt - wbase, len);
      for (int i = 0; i < len; i++) begin
        check(wlog_a[wbase + i] == eptr + 15'(i), "R4 R2 write address",
              wlog_a[wbase + i], eptr + 15'(i));
        check(wlog_d[wbase + i] == d0 + 8'(i), "R3 write data", wlog_d[wbase + i], d0 + 8'(i));
      end

      // pointer write then repeated START into a read burst
      bus_start();
      send_byte(8'hD0, nak);
      send_byte(hi, nak);
      send_byte(lo, nak);
      bus_start();
      send_byte(8'hD1, nak);
      check(nak == 1'b0, "R7 repeated start read address acked", nak, 0);
      rd_all = 1'b1;
      for (int i = 0; i < len; i++) begin
        recv_byte(i == len - 1, v, rd_seen);
        rd_all &= rd_seen;
        check(v == d0 + 8'(i), "R6 read burst data", v, d0 + 8'(i));
      end
      bus_stop();
      check(rd_all, "R9 read flag during read", rd_all, 1);

      // current-address read: pointer left on the last byte sent
      bus_start();
      send_byte(8'hD1, nak);
      recv_byte(1'b1, v, rd_seen);
      check(v == d0 + 8'(len - 1), "R5 current address read", v, d0 + 8'(len - 1));
      // after a NACK the target stays off the bus
      recv_byte(1'b1, v, rd_seen);
      check(v == 8'hFF && rd_seen == 1'b0, "R6 silent after nack", {rd_seen, v}, 8'hFF);
      bus_stop();
    end

    // R1: wrong device address, later bytes ignored until START
    wbase = wcnt;
    sbase = stop_cnt;
    bus_start();
    send_byte(8'hA0, nak);
    check(nak == 1'b1, "R1 foreign address not acked", nak, 1);
    send_byte(8'hD0, nak);
    check(nak == 1'b1, "R1 later byte ignored", nak, 1);
    send_byte(8'h55, nak);
    bus_stop();
    check(wcnt == wbase, "R1 no write after foreign address", wcnt - wbase, 0);
    repeat (20) @(negedge clk);
    check(stop_cnt - sbase == 1, "R7 one stop pulse", stop_cnt - sbase, 1);

    // R8: supply fail in the middle of a data byte
    wbase = wcnt;
    bus_start();
    send_byte(8'hD0, nak);
    send_byte(8'h00, nak);
    send_byte(8'h05, nak);
    clk_bit(1'b0, nak);
    clk_bit(1'b1, nak);
    clk_bit(1'b1, nak);
    clk_bit(1'b1, nak);
    pfail = 1'b1;
    waitq();
    check(sda_oe == 1'b0, "R8 sda released on fail", sda_oe, 0);
    check(mem_addr == 15'h0, "R8 pointer cleared", mem_addr, 0);
    clk_bit(1'b0, nak);
    clk_bit(1'b1, nak);
    clk_bit(1'b1, nak);
    clk_bit(1'b1, nak);
    clk_bit(1'b1, nak);
    check(nak == 1'b1, "R8 no ack while failed", nak, 1);
    pfail = 1'b0;
    waitq();
    bus_stop();
    check(wcnt == wbase, "R8 no write while failed", wcnt - wbase, 0);
    // vector 1 left 8'h3E at 0000h through the wrap
    bus_start();
    send_byte(8'hD1, nak);
    recv_byte(1'b1, v, rd_seen);
    bus_stop();
    check(v == 8'h3E, "R8 R4 read after fail at 0000h", v, 8'h3E);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule